// File: doc/BRIEF.md
# Regulator Fault Protection Manager

This block is the protection state machine for one channel of a synchronous buck regulator. The analog comparators sit outside it and deliver flags that are already digitised and synchronous to the block clock. There is one flag each for output overvoltage, output undervoltage, inductor overcurrent, die over-temperature and supply undervoltage lockout. A channel enable comes in beside them. From these inputs the block decides four things: whether the high-side switch may be driven, whether the low-side switch is forced on or off, whether the output discharge path is closed, and whether the current PWM on-pulse must be cut short.

Overvoltage, overcurrent and undervoltage each have their own persistence timer, counted in clock cycles. When a timer expires, its fault latches. A latched fault holds until the channel enable drops or the supply lockout flag rises. Over-temperature and supply lockout never latch: they act immediately and outrank everything else. A latched overvoltage outranks overcurrent and undervoltage, and it stops their timers. While an overvoltage is latched, the low-side switch tracks the live overvoltage comparator so that the output is pulled down. Every other fault turns both switches off. A three-bit code reports the highest-ranked fault that is active or latched.

All pins are plain level control and status signals. The block has no data stream, so no pin uses a valid/ready handshake.

Top module: `buck_prot_mgr`

## Requirements
- R1: While rst_n is low, all three fault latches are clear. After reset, with the channel disabled, the outputs show hs_gate_en_o=0, ls_force_off_o=1 and discharge_o=1, fault_latched_o=0 and fault_code_o=0.
- R2: With the channel running normally, cl_term_o follows oc_flag_i in the same cycle and hs_gate_en_o stays 1.
- R3: Overcurrent latches only after oc_flag_i has been high for OC_CYC consecutive clock edges. A shorter burst sets nothing, and any cycle with the flag low restarts the count.
- R4: Overvoltage latches only after ov_flag_i has been high for OV_CYC consecutive clock edges. A shorter burst is forgotten once the flag releases.
- R5: While an overvoltage is latched and no supply or thermal fault is present: hs_gate_en_o=0, ls_force_on_o equals ov_flag_i, and ls_force_off_o is its complement. ls_force_on_o and ls_force_off_o are never both 1.
- R6: Undervoltage latches after uv_flag_i has been high for UV_CYC consecutive edges. While an overvoltage is latched, the undervoltage and overcurrent timers are held idle and those two flags change no output.
- R7: After an overcurrent or undervoltage latch with no overvoltage latched: hs_gate_en_o=0, ls_force_on_o=0 and ls_force_off_o=1.
- R8: A latched fault persists until ch_en_i is low or uvlo_flag_i is high at a clock edge. The thermal flag does not clear it.
- R9: discharge_o is 1 whenever ch_en_i is low, a thermal or supply flag is high, or any fault is latched, and it is 0 otherwise.
- R10: A high thermal or supply flag forces hs_gate_en_o=0, ls_force_off_o=1 and fault_code_o=4 at once. It overrides a latched overvoltage and holds all three timers at zero.
- R11: fault_code_o encodes 0 none, 1 undervoltage, 2 overcurrent, 3 overvoltage, 4 thermal/supply. It picks the highest of these that is either latched or, with the channel enabled, currently flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en_i | input | 1 | Channel enable level |
| ov_flag_i | input | 1 | Output overvoltage comparator flag |
| uv_flag_i | input | 1 | Output undervoltage comparator flag |
| oc_flag_i | input | 1 | Overcurrent comparator flag |
| hot_flag_i | input | 1 | Over-temperature flag |
| uvlo_flag_i | input | 1 | Supply undervoltage lockout flag |
| hs_gate_en_o | output | 1 | High-side drive permitted |
| ls_force_on_o | output | 1 | Force low-side switch on |
| ls_force_off_o | output | 1 | Force low-side switch off |
| discharge_o | output | 1 | Close output discharge path |
| cl_term_o | output | 1 | Terminate current on-pulse |
| fault_code_o | output | 3 | Highest-ranked fault code |
| fault_latched_o | output | 1 | Any fault latched |

## Verification
The assertions assume that every flag is already synchronised to clk and holds its value across each edge, and that the enable is a level, not a pulse. No assertion considers metastable or sub-cycle glitches. The stimulus changes inputs only 1 ns after a rising edge and holds each setting for whole cycles. Short timer limits are passed as overrides, so that bursts of exactly limit minus one and exactly the limit can be applied in a compact sequence.

// File: rtl/buck_prot_pkg.sv
package buck_prot_pkg;
  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_UV     = 3'd1,
    FC_OC     = 3'd2,
    FC_OV     = 3'd3,
    FC_SUPPLY = 3'd4
  } fault_code_t;

  localparam int NUM_TIMED = 3;
  localparam int IDX_OV = 0;
  localparam int IDX_OC = 1;
  localparam int IDX_UV = 2;
endpackage

// File: rtl/prot_persist_timer.sv
module prot_persist_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic mask_i,
  input  logic cond_i,
  input  logic clr_i,
  output logic latched_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          lat_q;
  logic          run;
  logic          hit;

  assign run = arm_i & ~mask_i & cond_i & ~lat_q & ~clr_i;
  assign hit = run & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else begin
      if (clr_i)    lat_q <= 1'b0;
      else if (hit) lat_q <= 1'b1;
      if (!run)     cnt_q <= '0;
      else if (!hit) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign latched_o = lat_q;

  // R3/R4/R6: a latch only rises after a cycle in which its condition was armed
  p_set_needs_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_o) |-> $past(cond_i && arm_i));
  p_hold_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && !clr_i) |=> latched_o);
  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && !latched_o) |=> !latched_o);
endmodule

// File: rtl/prot_out_arbiter.sv
module prot_out_arbiter
  import buck_prot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 ov_i,
  input  logic                 uv_i,
  input  logic                 oc_i,
  input  logic                 hot_i,
  input  logic                 uvlo_i,
  input  logic [NUM_TIMED-1:0] lat_i,
  output logic                 hs_en_o,
  output logic                 ls_on_o,
  output logic                 ls_off_o,
  output logic                 discharge_o,
  output logic                 cl_term_o,
  output logic [2:0]           code_o
);
  logic        supply_bad;
  logic        any_lat;
  fault_code_t code;

  assign supply_bad = hot_i | uvlo_i;
  assign any_lat    = |lat_i;

  always_comb begin
    hs_en_o   = 1'b0;
    ls_on_o   = 1'b0;
    ls_off_o  = 1'b1;
    cl_term_o = 1'b0;
    if (!en_i || supply_bad) begin
      ls_off_o = 1'b1;
    end else if (lat_i[IDX_OV]) begin
      ls_on_o  = ov_i;
      ls_off_o = ~ov_i;
    end else if (any_lat) begin
      ls_off_o = 1'b1;
    end else begin
      hs_en_o   = 1'b1;
      ls_off_o  = 1'b0;
      cl_term_o = oc_i;
    end
  end

  assign discharge_o = ~en_i | supply_bad | any_lat;

  always_comb begin
    if (supply_bad)                        code = FC_SUPPLY;
    else if (lat_i[IDX_OV] || (en_i && ov_i)) code = FC_OV;
    else if (lat_i[IDX_OC] || (en_i && oc_i)) code = FC_OC;
    else if (lat_i[IDX_UV] || (en_i && uv_i)) code = FC_UV;
    else                                   code = FC_NONE;
  end
  assign code_o = code;

  p_ls_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_on_o && ls_off_o));
  p_hs_off_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_lat |-> !hs_en_o);
  p_discharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> discharge_o);
  p_thermal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |-> (code_o == 3'd4 && !hs_en_o && !ls_on_o));
  p_clterm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cl_term_o |-> (oc_i && hs_en_o));
endmodule

// File: rtl/buck_prot_mgr.sv
module buck_prot_mgr
  import buck_prot_pkg::*;
#(
  parameter int OV_CYC = 375,
  parameter int OC_CYC = 13250,
  parameter int UV_CYC = 6750
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_en_i,
  input  logic       ov_flag_i,
  input  logic       uv_flag_i,
  input  logic       oc_flag_i,
  input  logic       hot_flag_i,
  input  logic       uvlo_flag_i,
  output logic       hs_gate_en_o,
  output logic       ls_force_on_o,
  output logic       ls_force_off_o,
  output logic       discharge_o,
  output logic       cl_term_o,
  output logic [2:0] fault_code_o,
  output logic       fault_latched_o
);
  localparam int LIM [NUM_TIMED] = '{OV_CYC, OC_CYC, UV_CYC};

  logic                 arm;
  logic                 clr;
  logic [NUM_TIMED-1:0] cond_vec;
  logic [NUM_TIMED-1:0] mask_vec;
  logic [NUM_TIMED-1:0] lat_vec;

  assign arm = ch_en_i & ~hot_flag_i & ~uvlo_flag_i;
  assign clr = ~ch_en_i | uvlo_flag_i;

  assign cond_vec[IDX_OV] = ov_flag_i;
  assign cond_vec[IDX_OC] = oc_flag_i;
  assign cond_vec[IDX_UV] = uv_flag_i;

  // a latched overvoltage outranks and freezes the lower-ranked timers
  assign mask_vec[IDX_OV] = 1'b0;
  assign mask_vec[IDX_OC] = lat_vec[IDX_OV];
  assign mask_vec[IDX_UV] = lat_vec[IDX_OV];

  for (genvar g = 0; g < NUM_TIMED; g++) begin : g_tmr
    prot_persist_timer #(.LIMIT(LIM[g])) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm),
      .mask_i    (mask_vec[g]),
      .cond_i    (cond_vec[g]),
      .clr_i     (clr),
      .latched_o (lat_vec[g])
    );
  end

  prot_out_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (ch_en_i),
    .ov_i        (ov_flag_i),
    .uv_i        (uv_flag_i),
    .oc_i        (oc_flag_i),
    .hot_i       (hot_flag_i),
    .uvlo_i      (uvlo_flag_i),
    .lat_i       (lat_vec),
    .hs_en_o     (hs_gate_en_o),
    .ls_on_o     (ls_force_on_o),
    .ls_off_o    (ls_force_off_o),
    .discharge_o (discharge_o),
    .cl_term_o   (cl_term_o),
    .code_o      (fault_code_o)
  );

  assign fault_latched_o = |lat_vec;

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en_i || uvlo_flag_i) |=> !fault_latched_o);
  p_ls_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_vec[IDX_OV] && ch_en_i && !hot_flag_i && !uvlo_flag_i)
      |-> (ls_force_on_o == ov_flag_i && !hs_gate_en_o));
endmodule

// File: tb/buck_prot_mgr_test.sv
`timescale 1ns/1ps
module buck_prot_mgr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, ov = 1'b0, uv = 1'b0, oc = 1'b0, hot = 1'b0, uvlo = 1'b0;
  logic       hs, lson, lsoff, dis, clt, lat;
  logic [2:0] code;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  buck_prot_mgr #(.OV_CYC(6), .OC_CYC(10), .UV_CYC(8)) uut (
    .clk(clk), .rst_n(rst_n), .ch_en_i(en), .ov_flag_i(ov), .uv_flag_i(uv),
    .oc_flag_i(oc), .hot_flag_i(hot), .uvlo_flag_i(uvlo),
    .hs_gate_en_o(hs), .ls_force_on_o(lson), .ls_force_off_o(lsoff),
    .discharge_o(dis), .cl_term_o(clt), .fault_code_o(code),
    .fault_latched_o(lat)
  );

  // entry: {en,ov,uv,oc,hot,uvlo}, edges held, {hs,lson,lsoff,dis,clt,lat,code}, requirement
  localparam int NV = 31;
  localparam logic [26:0] VEC [NV] = '{
    {6'b100000, 8'd2,  9'b100000000, 4'd2},  // R2 normal run
    {6'b100100, 8'd3,  9'b100010010, 4'd2},  // R2 pulse terminate
    {6'b100000, 8'd1,  9'b100000000, 4'd3},  // R3 timer restarts
    {6'b100100, 8'd9,  9'b100010010, 4'd3},  // R3 limit-1 no latch
    {6'b100000, 8'd1,  9'b100000000, 4'd3},
    {6'b100100, 8'd10, 9'b001101010, 4'd3},  // R3 latch at limit
    {6'b100000, 8'd3,  9'b001101010, 4'd8},  // R8 holds
    {6'b100010, 8'd1,  9'b001101100, 4'd10}, // R10 thermal on top
    {6'b100000, 8'd2,  9'b001101010, 4'd8},  // R8 thermal no clear
    {6'b000000, 8'd1,  9'b001100000, 4'd8},  // R8 enable low clears
    {6'b100000, 8'd1,  9'b100000000, 4'd8},
    {6'b110000, 8'd5,  9'b100000011, 4'd4},  // R4 short burst
    {6'b100000, 8'd1,  9'b100000000, 4'd4},
    {6'b110000, 8'd6,  9'b010101011, 4'd4},  // R4 latch
    {6'b100000, 8'd2,  9'b001101011, 4'd5},  // R5 follow low
    {6'b110000, 8'd1,  9'b010101011, 4'd5},  // R5 follow high
    {6'b101000, 8'd12, 9'b001101011, 4'd6},  // R6 UV masked
    {6'b100100, 8'd12, 9'b001101011, 4'd6},  // R6 OC masked
    {6'b100001, 8'd1,  9'b001100100, 4'd10}, // R10 UVLO clears
    {6'b100000, 8'd1,  9'b100000000, 4'd8},
    {6'b101000, 8'd7,  9'b100000001, 4'd6},  // R6 below limit
    {6'b101000, 8'd1,  9'b001101001, 4'd6},  // R6 latch
    {6'b101100, 8'd1,  9'b001101010, 4'd11}, // R11 OC over UV
    {6'b111100, 8'd1,  9'b001101011, 4'd11}, // R11 OV over OC
    {6'b011100, 8'd1,  9'b001100000, 4'd9},  // R9 disabled
    {6'b000010, 8'd1,  9'b001100100, 4'd10},
    {6'b100000, 8'd1,  9'b100000000, 4'd9},  // R9 off in run
    {6'b110010, 8'd8,  9'b001100100, 4'd10}, // R10 timers frozen
    {6'b110000, 8'd1,  9'b100000011, 4'd10},
    {6'b101000, 8'd8,  9'b001101001, 4'd7},  // R7 both off
    {6'b100000, 8'd1,  9'b001101001, 4'd7}
  };

  task automatic check(input logic [8:0] exp, input int req);
    logic [8:0] got;
    got = {hs, lson, lsoff, dis, clt, lat, code};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [5:0] s);
    {en, ov, uv, oc, hot, uvlo} = s;
  endtask

  initial begin
    // R1: latches held clear during reset even with a persistent flag
    apply(6'b100100);
    repeat (15) @(posedge clk);
    #1;
    checks++;
    if (lat !== 1'b0) begin
      fails++;
      $display("FAIL R1 got latched=%b expected 0", lat);
    end
    apply(6'b000000);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(9'b001100000, 1); // R1 disabled idle state
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][26:21]);
      repeat (int'(VEC[i][20:13])) @(posedge clk);
      #1;
      check(VEC[i][12:4], int'(VEC[i][3:0]));
    end
    // R1: asynchronous reset drops an existing latch
    apply(6'b100100);
    repeat (10) @(posedge clk); #1;
    check(9'b001101010, 3);
    rst_n = 1'b0;
    #1;
    check(9'b100010010, 1); // R1 back to normal drive, no latch
    apply(6'b000000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule